// File: doc/BRIEF.md
# Nested Interrupt Acknowledge Controller

This block is the processor-facing half of a multi-input interrupt controller. Every cycle it looks at the interrupts that are both enabled and pending for its processor, and picks the most urgent one. A lower priority number is more urgent, and the lowest interrupt number wins a tie. The winner is offered to the processor only if its priority passes a programmable mask. The request line is raised only if the winner would also preempt whatever is already being serviced. Enable bits, pending bits, priorities, trigger types, targets and the 1-of-N model flags all come from a distributor outside this block, as input vectors.

Software talks to the block through a small register window. Reading the acknowledge register claims the selected interrupt. The claimed interrupt becomes the running one, and the block emits a one-cycle request for the distributor to clear its pending bit. Writing an interrupt number to the end-of-interrupt register retires it. Each claimed interrupt remembers which interrupt it preempted, which forms a chain of links. Retiring the running interrupt resumes its predecessor. Retiring an interrupt further down the chain removes it from the chain with a short walk, one link per cycle.

The control FSM has three states. `ST_IDLE` means nothing is running. `ST_RUN` means an interrupt is being serviced. `ST_WALK` means an out-of-order retirement is unlinking an entry. Its transitions are:
- `ST_IDLE` to `ST_RUN` on a successful acknowledge.
- `ST_RUN` to `ST_RUN` on a nested acknowledge, or on retiring the running interrupt while a predecessor remains.
- `ST_RUN` to `ST_IDLE` on retiring the running interrupt when its link is the idle ID.
- `ST_RUN` to `ST_WALK` on retiring any ID other than the running one.
- `ST_WALK` to `ST_RUN` when the walk reaches a link equal to the retired ID, or reaches a link equal to the idle ID.

Top module: `irq_ack_ctrl`

## Requirements
- R1: The selected candidate is the enabled, pending interrupt with the numerically lowest priority. Among equal priorities, the lowest interrupt number is selected.
- R2: The highest-pending value (offset 0x18) is the selected ID if its priority is less than or equal to the mask; otherwise it is 1023. It is also 1023 whenever `dist_enable` or the control bit is 0.
- R3: `irq_req` is registered. It is high in the cycle after one in which the highest-pending ID is not 1023 and its priority is strictly below the running priority. It is low in every other cycle.
- R4: After reset the control bit is 0, the mask is 0xF0, the running priority is 0x100 (no interrupt running), the highest-pending value is 1023 and `irq_req` is low.
- R5: A read of offset 0x0C succeeds when the R3 condition holds. It then returns the ID one cycle later, and pulses `pend_clr_valid` with `pend_clr_id` set to that ID. `pend_clr_all` is set to that interrupt's `irq_one_of_n` bit (1 means clear for every processor). The ID becomes running with its own priority. If the R3 condition does not hold, the read returns 1023 and changes nothing.
- R6: An end-of-interrupt write (offset 0x10, ID in bits 9:0) while nothing is running has no effect: the running priority stays 0x100 and no re-pend pulse is issued.
- R7: An end-of-interrupt for the running ID restores the running ID from that interrupt's stored link. The running priority becomes the priority of the restored ID, or 0x100 if the link is 1023.
- R8: An end-of-interrupt for a non-running ID leaves the running ID and priority unchanged. It splices that ID out of the chain, so the interrupt it had preempted is resumed directly by the one that preempted it.
- R9: When an end-of-interrupt is accepted, a one-cycle `pend_set_valid` with `pend_set_id` equal to the written ID is issued in the following cycle if that interrupt is enabled, level-sensitive (`irq_edge`=0), has its level high and targets this processor.
- R10: Register reads return their value one cycle later. The fields are: 0x00 control (bit 0), 0x04 mask (bits 7:0), 0x14 running priority (bits 8:0), 0x18 highest pending (bits 9:0). Any other offset reads 0.
- R11: While a chain walk is in progress, acknowledge reads return 1023 with no effect and end-of-interrupt writes are ignored. A walk for an ID at chain position k (running ID at position 0) lasts k cycles. A walk for an ID not in the chain lasts as many cycles as the chain is long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_enable | input | 1 | Global enable from the distributor |
| irq_enable | input | NUM_IRQ | Per-interrupt enable |
| irq_pending | input | NUM_IRQ | Per-interrupt pending bit for this processor |
| irq_level | input | NUM_IRQ | Current input level of each interrupt |
| irq_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| irq_here | input | NUM_IRQ | Interrupt targets this processor |
| irq_one_of_n | input | NUM_IRQ | 1 = 1-of-N model, 0 = N-of-N |
| irq_prio | input | NUM_IRQ*PRIO_W | Packed priorities, interrupt i at bits i*PRIO_W |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq_req | output | 1 | Interrupt request to the processor |
| pend_clr_valid | output | 1 | Request to clear a pending bit (on acknowledge) |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_all | output | 1 | Clear for all processors rather than this one |
| pend_set_valid | output | 1 | Request to set a pending bit again (level re-pend) |
| pend_set_id | output | 10 | ID to re-pend |

## Verification
On every cycle, the embedded assertions check the following:
- The request line stays low after any cycle in which the block was disabled.
- The running priority is 0x100 exactly when the running ID is 1023.
- Each clear pulse names the interrupt that has just become running.
- A retirement while idle changes nothing.
- The running ID is frozen during a walk, and no walk lasts longer than the interrupt count.

Only the bench's scenarios can show the following:
- The selection order and tie break.
- The mask and strict-preemption boundaries.
- That an out-of-order retirement really shortens the chain, which only appears when later retirements skip the removed entry.
- The level re-pend condition.

The bench's behavioural model keeps the chain as a queue and compares the request line, the read data and both pulse outputs on every clock.

// File: rtl/irqack_pkg.sv
package irqack_pkg;

    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] IDLE_ID = 10'd1023;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MASK = 8'h04;
    localparam logic [7:0] OFS_ACK  = 8'h0C;
    localparam logic [7:0] OFS_EOI  = 8'h10;
    localparam logic [7:0] OFS_RPRI = 8'h14;
    localparam logic [7:0] OFS_HPND = 8'h18;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WALK = 2'd2
    } ack_state_t;

endpackage

// File: rtl/irqack_prio_tree.sv
module irqack_prio_tree #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      best_valid,
    output logic [IDX_W-1:0]          best_idx,
    output logic [PRIO_W-1:0]         best_prio
);

    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES;

    logic              nv [1:NODES-1];
    logic [PRIO_W-1:0] np [1:NODES-1];
    logic [IDX_W-1:0]  ni [1:NODES-1];

    // Leaves: real inputs, then padding that never wins.
    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        if (g < NUM_IRQ) begin : g_real
            assign nv[LEAVES+g] = cand[g];
            assign np[LEAVES+g] = prio_flat[g*PRIO_W +: PRIO_W];
            assign ni[LEAVES+g] = IDX_W'(g);
        end else begin : g_pad
            assign nv[LEAVES+g] = 1'b0;
            assign np[LEAVES+g] = '1;
            assign ni[LEAVES+g] = IDX_W'(g);
        end
    end

    // Inner nodes: the left subtree holds lower IDs, so it wins ties.
    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        logic take_l;
        assign take_l = nv[2*k] && (!nv[2*k+1] || (np[2*k] <= np[2*k+1]));
        assign nv[k]  = nv[2*k] | nv[2*k+1];
        assign np[k]  = take_l ? np[2*k] : np[2*k+1];
        assign ni[k]  = take_l ? ni[2*k] : ni[2*k+1];
    end

    assign best_valid = nv[1];
    assign best_idx   = ni[1];
    assign best_prio  = np[1];

    // R1
    always_comb begin
        if (best_valid) begin
            tree_pick_chk: assert (cand[best_idx]);
        end
    end

endmodule

// File: rtl/irqack_link_store.sv
module irqack_link_store #(
    parameter int NUM_IRQ = 32,
    parameter int ID_W    = 10,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ID_W-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [ID_W-1:0]  rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [ID_W-1:0]  rd_b_data
);

    logic [ID_W-1:0] link_mem [NUM_IRQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                link_mem[i] <= '1;
            end
        end else if (wr_en) begin
            link_mem[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = link_mem[rd_a_idx];
    assign rd_b_data = link_mem[rd_b_idx];

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irqack_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dist_enable,
    input  logic [NUM_IRQ-1:0]        irq_enable,
    input  logic [NUM_IRQ-1:0]        irq_pending,
    input  logic [NUM_IRQ-1:0]        irq_level,
    input  logic [NUM_IRQ-1:0]        irq_edge,
    input  logic [NUM_IRQ-1:0]        irq_here,
    input  logic [NUM_IRQ-1:0]        irq_one_of_n,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic                      reg_rd,
    input  logic                      reg_wr,
    input  logic [7:0]                reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      irq_req,
    output logic                      pend_clr_valid,
    output logic [ID_W-1:0]           pend_clr_id,
    output logic                      pend_clr_all,
    output logic                      pend_set_valid,
    output logic [ID_W-1:0]           pend_set_id
);

    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int RP_W  = PRIO_W + 1;
    localparam logic [RP_W-1:0]   RP_IDLE  = {1'b1, {PRIO_W{1'b0}}};
    localparam logic [PRIO_W-1:0] MASK_RST = PRIO_W'(8'hF0);

    ack_state_t        state, nstate;
    logic              cpu_en;
    logic [PRIO_W-1:0] mask;
    logic [ID_W-1:0]   run_id;
    logic [RP_W-1:0]   run_prio;
    logic [IDX_W-1:0]  cursor;
    logic [ID_W-1:0]   target;

    logic              best_valid;
    logic [IDX_W-1:0]  best_idx;
    logic [PRIO_W-1:0] best_prio;
    logic              qual, preempt;
    logic [ID_W-1:0]   hp_id;

    logic              ack_ok, eoi_wr, eoi_is_run, eoi_repend;
    logic [ID_W-1:0]   eoi_id;
    logic [IDX_W-1:0]  eoi_idx;
    logic [IDX_W-1:0]  lk_a_idx;
    logic [ID_W-1:0]   link_a, link_b;
    logic              walk_hit, walk_done;
    logic              lk_we;
    logic [IDX_W-1:0]  lk_widx;
    logic [ID_W-1:0]   lk_wdata;
    logic [31-ID_W:0]  unused_wdata;

    assign unused_wdata = reg_wdata[31:ID_W];

    function automatic logic [PRIO_W-1:0] prio_at(input logic [IDX_W-1:0] idx);
        return irq_prio[int'(idx)*PRIO_W +: PRIO_W];
    endfunction

    // ---------------- selection ----------------
    irqack_prio_tree #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_tree (
        .cand       (irq_enable & irq_pending),
        .prio_flat  (irq_prio),
        .best_valid (best_valid),
        .best_idx   (best_idx),
        .best_prio  (best_prio)
    );

    assign qual    = dist_enable && cpu_en && best_valid && (best_prio <= mask);
    assign hp_id   = qual ? ID_W'(best_idx) : IDLE_ID;
    assign preempt = qual && ({1'b0, best_prio} < run_prio);

    // ---------------- register decode ----------------
    assign eoi_id     = reg_wdata[ID_W-1:0];
    assign eoi_idx    = eoi_id[IDX_W-1:0];
    assign ack_ok     = reg_rd && !reg_wr && (reg_addr == OFS_ACK) &&
                        (state != ST_WALK) && preempt;
    assign eoi_wr     = reg_wr && (reg_addr == OFS_EOI) && (state == ST_RUN);
    assign eoi_is_run = (eoi_id == run_id);
    assign eoi_repend = eoi_wr && (int'(eoi_id) < NUM_IRQ) && !irq_edge[eoi_idx] &&
                        irq_enable[eoi_idx] && irq_level[eoi_idx] && irq_here[eoi_idx];

    // ---------------- preemption chain ----------------
    assign lk_a_idx  = (state == ST_WALK) ? cursor : run_id[IDX_W-1:0];
    assign walk_hit  = (link_a != IDLE_ID) && (link_a == target);
    assign walk_done = (link_a == IDLE_ID) || walk_hit;

    always_comb begin
        lk_we    = 1'b0;
        lk_widx  = best_idx;
        lk_wdata = run_id;
        if (ack_ok) begin
            lk_we = 1'b1;
        end else if ((state == ST_WALK) && walk_hit) begin
            lk_we    = 1'b1;
            lk_widx  = cursor;
            lk_wdata = link_b;
        end
    end

    irqack_link_store #(
        .NUM_IRQ (NUM_IRQ),
        .ID_W    (ID_W),
        .IDX_W   (IDX_W)
    ) u_links (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (lk_we),
        .wr_idx    (lk_widx),
        .wr_data   (lk_wdata),
        .rd_a_idx  (lk_a_idx),
        .rd_a_data (link_a),
        .rd_b_idx  (target[IDX_W-1:0]),
        .rd_b_data (link_b)
    );

    // ---------------- FSM ----------------
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (ack_ok) nstate = ST_RUN;
            end
            ST_RUN: begin
                if (eoi_wr) begin
                    if (!eoi_is_run)              nstate = ST_WALK;
                    else if (link_a == IDLE_ID)   nstate = ST_IDLE;
                end
            end
            ST_WALK: begin
                if (walk_done) nstate = ST_RUN;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_en   <= 1'b0;
            mask     <= MASK_RST;
            run_id   <= IDLE_ID;
            run_prio <= RP_IDLE;
            cursor   <= '0;
            target   <= IDLE_ID;
        end else begin
            if (reg_wr && (reg_addr == OFS_CTRL)) cpu_en <= reg_wdata[0];
            if (reg_wr && (reg_addr == OFS_MASK)) mask   <= reg_wdata[PRIO_W-1:0];
            if (ack_ok) begin
                run_id   <= hp_id;
                run_prio <= {1'b0, best_prio};
            end else if (eoi_wr) begin
                if (eoi_is_run) begin
                    run_id   <= link_a;
                    run_prio <= (link_a == IDLE_ID) ? RP_IDLE
                                                    : {1'b0, prio_at(link_a[IDX_W-1:0])};
                end else begin
                    cursor <= run_id[IDX_W-1:0];
                    target <= eoi_id;
                end
            end else if ((state == ST_WALK) && !walk_done) begin
                cursor <= link_a[IDX_W-1:0];
            end
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata      <= '0;
            irq_req        <= 1'b0;
            pend_clr_valid <= 1'b0;
            pend_clr_id    <= '0;
            pend_clr_all   <= 1'b0;
            pend_set_valid <= 1'b0;
            pend_set_id    <= '0;
        end else begin
            irq_req        <= preempt;
            pend_clr_valid <= ack_ok;
            pend_clr_id    <= hp_id;
            pend_clr_all   <= irq_one_of_n[best_idx];
            pend_set_valid <= eoi_repend;
            pend_set_id    <= eoi_id;
            if (reg_rd) begin
                case (reg_addr)
                    OFS_CTRL: reg_rdata <= {31'b0, cpu_en};
                    OFS_MASK: reg_rdata <= 32'(mask);
                    OFS_ACK:  reg_rdata <= ack_ok ? 32'(hp_id) : 32'(IDLE_ID);
                    OFS_RPRI: reg_rdata <= 32'(run_prio);
                    OFS_HPND: reg_rdata <= 32'(hp_id);
                    default:  reg_rdata <= '0;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    logic [IDX_W+1:0] walk_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                walk_cnt <= '0;
        else if (state == ST_WALK) walk_cnt <= walk_cnt + 1'b1;
        else                       walk_cnt <= '0;
    end

    // R3
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dist_enable && cpu_en) |-> !irq_req);

    // R4
    idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == IDLE_ID) == (run_prio == RP_IDLE));

    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_valid |-> (run_id == pend_clr_id) && (reg_rdata[ID_W-1:0] == pend_clr_id));

    // R6
    idle_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) == ST_IDLE) && $past(reg_wr && (reg_addr == OFS_EOI)))
        |-> ((run_id == IDLE_ID) && !pend_set_valid));

    // R11
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WALK) |-> (run_id == $past(run_id)));

    // R11
    walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(walk_cnt) <= NUM_IRQ);

endmodule

// File: tb/irq_ack_ctrl_bench.sv
module irq_ack_ctrl_bench;

    localparam int N  = 32;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            dist_en = 1'b0;
    logic [N-1:0]    en = '0, pend = '0, lvl = '0, edg = '0, here = '0, onen = '0;
    logic [PW-1:0]   pr [N];
    logic [N*PW-1:0] prio_flat;
    logic            reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq_req, pend_clr_valid, pend_clr_all, pend_set_valid;
    logic [9:0]      pend_clr_id, pend_set_id;

    always_comb begin
        for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = pr[i];
    end

    irq_ack_ctrl #(.NUM_IRQ(N), .PRIO_W(PW)) u_irq_ack_ctrl (
        .clk(clk), .rst_n(rst_n), .dist_enable(dist_en),
        .irq_enable(en), .irq_pending(pend), .irq_level(lvl), .irq_edge(edg),
        .irq_here(here), .irq_one_of_n(onen), .irq_prio(prio_flat),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req),
        .pend_clr_valid(pend_clr_valid), .pend_clr_id(pend_clr_id), .pend_clr_all(pend_clr_all),
        .pend_set_valid(pend_set_valid), .pend_set_id(pend_set_id)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  q[$];
    int  m_en, m_mask, m_rp, walk_left;
    int  bi, bp, hp, k, id;
    bit  pre, busy;
    bit  e_req, e_rd, e_clr, e_clr_all, e_set;
    int  e_rdata, e_clr_id, e_set_id;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_en = 0; m_mask = 'hF0; m_rp = 256; walk_left = 0;
            e_req = 0; e_rd = 0; e_clr = 0; e_set = 0;
        end else begin
            bi = -1; bp = 256;
            for (int i = 0; i < N; i++)
                if (en[i] && pend[i] && int'(pr[i]) < bp) begin bp = int'(pr[i]); bi = i; end
            hp  = (dist_en && m_en != 0 && bi >= 0 && bp <= m_mask) ? bi : 1023;
            pre = (hp != 1023) && (bp < m_rp);
            e_req = pre; e_clr = 0; e_set = 0; e_rd = reg_rd;
            busy = (walk_left > 0);
            if (busy) walk_left--;
            if (reg_rd) begin
                case (reg_addr)
                    8'h00: e_rdata = m_en;
                    8'h04: e_rdata = m_mask;
                    8'h14: e_rdata = m_rp;
                    8'h18: e_rdata = hp;
                    8'h0C: begin
                        if (!busy && !reg_wr && pre) begin
                            e_rdata = hp; e_clr = 1; e_clr_id = hp; e_clr_all = onen[hp];
                            q.push_front(hp); m_rp = bp;
                        end else e_rdata = 1023;
                    end
                    default: e_rdata = 0;
                endcase
            end
            if (reg_wr) begin
                case (reg_addr)
                    8'h00: m_en = int'(reg_wdata[0]);
                    8'h04: m_mask = int'(reg_wdata[7:0]);
                    8'h10: if (!busy && q.size() > 0) begin
                        id = int'(reg_wdata[9:0]);
                        if (id < N && !edg[id] && en[id] && lvl[id] && here[id]) begin
                            e_set = 1; e_set_id = id;
                        end
                        if (id == q[0]) begin
                            void'(q.pop_front());
                            m_rp = (q.size() > 0) ? int'(pr[q[0]]) : 256;
                        end else begin
                            k = q.size();
                            for (int j = 1; j < q.size(); j++)
                                if (q[j] == id && k == q.size()) k = j;
                            walk_left = k;
                            if (k < q.size()) q.delete(k);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq_req === e_req, "R3 request line vs model", irq_req, e_req);
            if (e_rd) chk(reg_rdata === e_rdata, "R10 read data vs model", reg_rdata, e_rdata);
            chk(pend_clr_valid === e_clr, "R5 clear pulse vs model", pend_clr_valid, e_clr);
            if (e_clr) begin
                chk(pend_clr_id == e_clr_id, "R5 clear id vs model", pend_clr_id, e_clr_id);
                chk(pend_clr_all == e_clr_all, "R5 clear scope vs model", pend_clr_all, e_clr_all);
            end
            chk(pend_set_valid === e_set, "R9 re-pend pulse vs model", pend_set_valid, e_set);
            if (e_set) chk(pend_set_id == e_set_id, "R9 re-pend id vs model", pend_set_id, e_set_id);
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- register tasks ----------------
    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; v = int'(reg_rdata);
    endtask

    task automatic wr(input logic [7:0] a, input int d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = 32'(d);
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int v;

    initial begin
        for (int i = 0; i < N; i++) pr[i] = 8'h80;
        en = '1; edg = '1; here = '1;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R4 reset state
        chk(irq_req == 1'b0, "R4 request low after reset", irq_req, 0);
        rd(8'h00, v); chk(v == 0, "R4 control after reset", v, 0);
        rd(8'h04, v); chk(v == 'hF0, "R4 mask after reset", v, 'hF0);
        rd(8'h14, v); chk(v == 'h100, "R4 running priority after reset", v, 'h100);
        rd(8'h18, v); chk(v == 1023, "R4 highest pending after reset", v, 1023);
        rd(8'h0C, v); chk(v == 1023, "R5 acknowledge with nothing pending", v, 1023);

        // R1 selection
        dist_en = 1'b1;
        wr(8'h00, 1);
        pr[5] = 8'h40; pr[3] = 8'h40; pr[9] = 8'h20;
        pend[3] = 1; pend[5] = 1; pend[9] = 1;
        idle(1);
        chk(irq_req == 1'b1, "R3 request raised for preempting candidate", irq_req, 1);
        rd(8'h18, v); chk(v == 9, "R1 lowest priority value wins", v, 9);
        pend[9] = 0;
        rd(8'h18, v); chk(v == 3, "R1 tie broken by lowest number", v, 3);

        // R2 mask and enables
        pend = '0; pr[30] = 8'hF8; pend[30] = 1;
        idle(2);
        chk(irq_req == 1'b0, "R2 masked candidate gives no request", irq_req, 0);
        rd(8'h18, v); chk(v == 1023, "R2 priority above mask", v, 1023);
        wr(8'h04, 'hFF);
        rd(8'h18, v); chk(v == 30, "R2 priority within mask", v, 30);
        wr(8'h04, 'hF0);
        pend[30] = 0; pend[3] = 1; pend[5] = 1;
        dist_en = 1'b0;
        rd(8'h18, v); chk(v == 1023, "R2 global enable clear", v, 1023);
        dist_en = 1'b1;

        // R5 acknowledge and nesting
        onen[3] = 1;
        rd(8'h0C, v); chk(v == 3, "R5 acknowledge returns selected id", v, 3);
        chk(pend_clr_valid && pend_clr_all, "R5 clear pulse for 1-of-N", pend_clr_all, 1);
        pend[3] = 0;
        rd(8'h14, v); chk(v == 'h40, "R5 running priority after acknowledge", v, 'h40);
        idle(1);
        chk(irq_req == 1'b0, "R3 equal priority does not preempt", irq_req, 0);
        rd(8'h18, v); chk(v == 5, "R2 pending shown while not preempting", v, 5);
        rd(8'h0C, v); chk(v == 1023, "R5 acknowledge without preemption", v, 1023);
        pend[9] = 1;
        rd(8'h0C, v); chk(v == 9, "R5 nested acknowledge", v, 9);
        chk(pend_clr_valid && !pend_clr_all, "R5 clear pulse for N-of-N", pend_clr_all, 0);
        pend[9] = 0;
        pr[12] = 8'h10; pend[12] = 1;
        rd(8'h0C, v); chk(v == 12, "R5 second nested acknowledge", v, 12);
        pend[12] = 0;

        // R8 out-of-order retire, R7 restore
        wr(8'h10, 9);
        idle(3);
        rd(8'h14, v); chk(v == 'h10, "R8 running kept after middle retire", v, 'h10);
        wr(8'h10, 12);
        rd(8'h14, v); chk(v == 'h40, "R8 retired entry skipped on restore", v, 'h40);
        wr(8'h10, 3);
        rd(8'h14, v); chk(v == 'h100, "R7 restore to idle", v, 'h100);

        // R6 retire while idle
        pend[5] = 0; edg[5] = 0; lvl[5] = 1;
        wr(8'h10, 5);
        chk(pend_set_valid == 1'b0, "R6 no re-pend while idle", pend_set_valid, 0);
        rd(8'h14, v); chk(v == 'h100, "R6 idle retire ignored", v, 'h100);
        edg[5] = 1; lvl[5] = 0;

        // R9 level re-pend
        edg[7] = 0; lvl[7] = 1; pr[7] = 8'h30; pend[7] = 1;
        rd(8'h0C, v); chk(v == 7, "R9 acknowledge level source", v, 7);
        pend[7] = 0;
        wr(8'h10, 7);
        chk(pend_set_valid && pend_set_id == 7, "R9 re-pend of held level", pend_set_id, 7);
        lvl[7] = 0; edg[7] = 1;

        // R11 walk blocks acknowledge
        pr[20] = 8'h60; pr[21] = 8'h50; pr[22] = 8'h40; pr[25] = 8'h08;
        pend[20] = 1; rd(8'h0C, v); pend[20] = 0;
        pend[21] = 1; rd(8'h0C, v); pend[21] = 0;
        pend[22] = 1; rd(8'h0C, v); pend[22] = 0;
        chk(v == 22, "R5 third level of nesting", v, 22);
        pend[25] = 1;
        wr(8'h10, 20);
        rd(8'h0C, v); chk(v == 1023, "R11 acknowledge ignored during walk", v, 1023);
        idle(4);
        rd(8'h0C, v); chk(v == 25, "R11 acknowledge after walk", v, 25);
        pend[25] = 0;
        wr(8'h10, 25);
        wr(8'h10, 22);
        rd(8'h14, v); chk(v == 'h50, "R7 restore through chain", v, 'h50);
        wr(8'h10, 21);
        rd(8'h14, v); chk(v == 'h100, "R8 deepest entry removed", v, 'h100);

        // R10 unmapped offset
        rd(8'h08, v); chk(v == 0, "R10 unmapped offset reads zero", v, 0);

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule